// File: doc/BRIEF.md
# Banked Register Window Decoder

This block is the host-facing register front end of a serial/infrared communications port. The host sees only eight byte locations, addressed by a 3-bit offset. Behind that window are eight banks of eight locations each. A shared byte at offset 03h is visible from every bank. It acts as a link-control register or as a bank selector, depending on its top bit. The block holds the selection state and routes every read and write to the physical register that the current bank and offset name.

Bank 0 holds the working registers of the port. Some of its offsets reach a different register on a read than on a write. Receive data and the event identification byte come from outside the block. Banks 1 to 7 each hold plain storage bytes, so that the routing can be observed through the bus alone. The serialiser, FIFOs, DMA and interrupt logic are separate blocks.

Top module: `banked_reg_window`

## Requirements
- R1: After reset (rstN low), activeBank is 0, every writable register (linkCtrl, txData, fifoCtrl, intEnable, modeCtrl, the bank 0 storage bytes and all storage bytes in banks 1 to 7) reads 00h, the byte at offset 03h reads 00h, rdData is 00h and txLoad is 0.
- R2: A write at offset 03h with bit 7 set selects bank wrData[6:0] when that value is 0 to 7, and selects bank 0 for any larger value. Such a write leaves linkCtrl unchanged.
- R3: A write at offset 03h with bit 7 clear copies the byte into linkCtrl and leaves activeBank unchanged.
- R4: A read at offset 03h returns the last byte written at offset 03h, including bit 7, whatever bank is active.
- R5: The bank chosen by a select write applies to the access in the very next cycle.
- R6: In bank 0, a read at offset 00h returns rxByte. A write at offset 00h loads txData and raises txLoad for exactly one cycle.
- R7: In bank 0, a read at offset 02h returns eventId. A write at offset 02h loads fifoCtrl and does not change what offset 02h reads.
- R8: In bank 0, offsets 01h (intEnable), 04h (modeCtrl), 05h, 06h and 07h are read/write bytes that return the value last written.
- R9: In banks 1 to 7, every offset other than 03h is a storage byte private to that bank and offset. Offsets 00h and 02h in those banks do not reach rxByte, eventId, txData or fifoCtrl.
- R10: rdData is registered. It takes the addressed value on the clock edge where rdEn is high, and it holds its value while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Window offset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rxByte | input | 8 | Receive data shown at bank 0 offset 00h |
| eventId | input | 8 | Event identification shown at bank 0 offset 02h |
| rdData | output | 8 | Registered read data |
| activeBank | output | 3 | Currently selected bank |
| linkCtrl | output | 8 | Link-control byte |
| txData | output | 8 | Last transmit byte written |
| txLoad | output | 1 | One-cycle pulse after a transmit write |
| fifoCtrl | output | 8 | FIFO control byte |
| intEnable | output | 8 | Interrupt enable byte |
| modeCtrl | output | 8 | Modem/mode control byte |

## Verification
Offset 03h is written with bit 7 clear, with in-range selects and with an out-of-range select. These patterns separate the link-control path from the bank path and show the fallback to bank 0. The same offsets are written with different values in bank 0, bank 2 and bank 5 and then read back from each bank. This exposes any bank that shares storage with another or ignores the selection. A select write followed at once by an access shows whether the new bank applies in the next cycle. Reads and writes at offsets 00h and 02h check that the read path and the write path at one offset are separate.

// File: rtl/bank_win_pkg.sv
package bank_win_pkg;
  parameter int WIN_ADDR_W = 3;
  parameter int WIN_DATA_W = 8;
  parameter int WIN_BANKS  = 8;
  localparam int BANK_W    = $clog2(WIN_BANKS);
  localparam int NUM_OFFS  = 1 << WIN_ADDR_W;

  localparam logic [WIN_ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [WIN_ADDR_W-1:0] OFS_IER  = 3'd1;
  localparam logic [WIN_ADDR_W-1:0] OFS_EVT  = 3'd2;
  localparam logic [WIN_ADDR_W-1:0] OFS_SEL  = 3'd3;
  localparam logic [WIN_ADDR_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [WIN_ADDR_W-1:0] OFS_LSR  = 3'd5;
  localparam logic [WIN_ADDR_W-1:0] OFS_MSR  = 3'd6;
  localparam logic [WIN_ADDR_W-1:0] OFS_SPR  = 3'd7;

  typedef struct packed {
    logic                  rdStb;
    logic [WIN_ADDR_W-1:0] offs;
    logic [BANK_W-1:0]     bank;
    logic                  wrTx;
    logic                  wrIer;
    logic                  wrFcr;
    logic                  wrMcr;
    logic                  wrLsr;
    logic                  wrMsr;
    logic                  wrSpr;
    logic                  wrAux;
  } winStrobe_t;
endpackage

// File: rtl/banked_win_ctrl.sv
module banked_win_ctrl
  import bank_win_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WIN_ADDR_W-1:0] addr,
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [WIN_DATA_W-1:0] wrData,
  output winStrobe_t            stb,
  output logic [BANK_W-1:0]     activeBank,
  output logic [WIN_DATA_W-1:0] linkCtrl,
  output logic [WIN_DATA_W-1:0] ctlEcho
);
  localparam int IDX_W = WIN_DATA_W - 1;

  logic               selWr;
  logic [IDX_W-1:0]   selIdx;
  logic [BANK_W-1:0]  selBank;

  assign selWr  = wrEn && (addr == OFS_SEL);
  assign selIdx = wrData[IDX_W-1:0];

  // An index beyond the implemented banks falls back to bank 0.
  always_comb begin
    if (selIdx < IDX_W'(WIN_BANKS)) selBank = selIdx[BANK_W-1:0];
    else                            selBank = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeBank <= '0;
      linkCtrl   <= '0;
      ctlEcho    <= '0;
    end else if (selWr) begin
      ctlEcho <= wrData;
      if (wrData[WIN_DATA_W-1]) activeBank <= selBank;
      else                      linkCtrl   <= wrData;
    end
  end

  logic inBank0;
  logic wrOther;
  assign inBank0 = (activeBank == '0);
  assign wrOther = wrEn && (addr != OFS_SEL);

  always_comb begin
    stb       = '0;
    stb.rdStb = rdEn;
    stb.offs  = addr;
    stb.bank  = activeBank;
    stb.wrTx  = wrOther && inBank0 && (addr == OFS_DATA);
    stb.wrIer = wrOther && inBank0 && (addr == OFS_IER);
    stb.wrFcr = wrOther && inBank0 && (addr == OFS_EVT);
    stb.wrMcr = wrOther && inBank0 && (addr == OFS_MCR);
    stb.wrLsr = wrOther && inBank0 && (addr == OFS_LSR);
    stb.wrMsr = wrOther && inBank0 && (addr == OFS_MSR);
    stb.wrSpr = wrOther && inBank0 && (addr == OFS_SPR);
    stb.wrAux = wrOther && !inBank0;
  end
endmodule

// File: rtl/banked_win_dp.sv
module banked_win_dp
  import bank_win_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  winStrobe_t            stb,
  input  logic [WIN_DATA_W-1:0] wrData,
  input  logic [WIN_DATA_W-1:0] rxByte,
  input  logic [WIN_DATA_W-1:0] eventId,
  input  logic [WIN_DATA_W-1:0] ctlEcho,
  output logic [WIN_DATA_W-1:0] rdData,
  output logic [WIN_DATA_W-1:0] txData,
  output logic                  txLoad,
  output logic [WIN_DATA_W-1:0] fifoCtrl,
  output logic [WIN_DATA_W-1:0] intEnable,
  output logic [WIN_DATA_W-1:0] modeCtrl
);
  logic [WIN_DATA_W-1:0] lsrReg;
  logic [WIN_DATA_W-1:0] msrReg;
  logic [WIN_DATA_W-1:0] sprReg;
  logic [WIN_DATA_W-1:0] bankRd [WIN_BANKS];
  logic [WIN_DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData    <= '0;
      txLoad    <= 1'b0;
      fifoCtrl  <= '0;
      intEnable <= '0;
      modeCtrl  <= '0;
      lsrReg    <= '0;
      msrReg    <= '0;
      sprReg    <= '0;
    end else begin
      txLoad <= stb.wrTx;
      if (stb.wrTx)  txData    <= wrData;
      if (stb.wrFcr) fifoCtrl  <= wrData;
      if (stb.wrIer) intEnable <= wrData;
      if (stb.wrMcr) modeCtrl  <= wrData;
      if (stb.wrLsr) lsrReg    <= wrData;
      if (stb.wrMsr) msrReg    <= wrData;
      if (stb.wrSpr) sprReg    <= wrData;
    end
  end

  assign bankRd[0] = '0;

  for (genvar b = 1; b < WIN_BANKS; b++) begin : g_bank
    logic [WIN_DATA_W-1:0] row [NUM_OFFS];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int o = 0; o < NUM_OFFS; o++) row[o] <= '0;
      end else if (stb.wrAux && (stb.bank == BANK_W'(b))) begin
        row[stb.offs] <= wrData;
      end
    end
    assign bankRd[b] = row[stb.offs];
  end

  always_comb begin
    if (stb.offs == OFS_SEL) begin
      rdNext = ctlEcho;
    end else if (stb.bank == '0) begin
      unique case (stb.offs)
        OFS_DATA: rdNext = rxByte;
        OFS_IER:  rdNext = intEnable;
        OFS_EVT:  rdNext = eventId;
        OFS_MCR:  rdNext = modeCtrl;
        OFS_LSR:  rdNext = lsrReg;
        OFS_MSR:  rdNext = msrReg;
        OFS_SPR:  rdNext = sprReg;
        default:  rdNext = '0;
      endcase
    end else begin
      rdNext = bankRd[stb.bank];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end
endmodule

// File: rtl/banked_reg_window.sv
module banked_reg_window
  import bank_win_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WIN_ADDR_W-1:0] addr,
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [WIN_DATA_W-1:0] wrData,
  input  logic [WIN_DATA_W-1:0] rxByte,
  input  logic [WIN_DATA_W-1:0] eventId,
  output logic [WIN_DATA_W-1:0] rdData,
  output logic [BANK_W-1:0]     activeBank,
  output logic [WIN_DATA_W-1:0] linkCtrl,
  output logic [WIN_DATA_W-1:0] txData,
  output logic                  txLoad,
  output logic [WIN_DATA_W-1:0] fifoCtrl,
  output logic [WIN_DATA_W-1:0] intEnable,
  output logic [WIN_DATA_W-1:0] modeCtrl
);
  winStrobe_t            stb;
  logic [WIN_DATA_W-1:0] ctlEcho;

  banked_win_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .stb(stb), .activeBank(activeBank),
    .linkCtrl(linkCtrl), .ctlEcho(ctlEcho)
  );

  banked_win_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rxByte(rxByte),
    .eventId(eventId), .ctlEcho(ctlEcho), .rdData(rdData), .txData(txData),
    .txLoad(txLoad), .fifoCtrl(fifoCtrl), .intEnable(intEnable),
    .modeCtrl(modeCtrl)
  );
endmodule

// File: rtl/banked_reg_window_chk.sv
module banked_reg_window_chk
  import bank_win_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [WIN_ADDR_W-1:0] addr,
  input logic                  rdEn,
  input logic                  wrEn,
  input logic [WIN_DATA_W-1:0] wrData,
  input logic [WIN_DATA_W-1:0] rdData,
  input logic [BANK_W-1:0]     activeBank,
  input logic [WIN_DATA_W-1:0] linkCtrl,
  input logic                  txLoad,
  input logic [WIN_DATA_W-1:0] fifoCtrl
);
  logic selHit;
  logic ctlHit;
  assign selHit = wrEn && (addr == OFS_SEL) && wrData[WIN_DATA_W-1];
  assign ctlHit = wrEn && (addr == OFS_SEL) && !wrData[WIN_DATA_W-1];

  AST_SEL_KEEPS_LINK: assert property (@(posedge clk) disable iff (!rstN)
    selHit |=> $stable(linkCtrl)); // R2

  AST_SEL_OVERRANGE: assert property (@(posedge clk) disable iff (!rstN)
    (selHit && (wrData[WIN_DATA_W-2:0] >= (WIN_DATA_W-1)'(WIN_BANKS))) |=> (activeBank == '0)); // R2

  AST_CTL_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    ctlHit |=> $stable(activeBank)); // R3

  AST_CTL_LOADS_LINK: assert property (@(posedge clk) disable iff (!rstN)
    ctlHit |=> (linkCtrl == $past(wrData))); // R3

  AST_TXLOAD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> $past(wrEn && (addr == OFS_DATA) && (activeBank == '0))); // R6

  AST_TXLOAD_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && !$past(wrEn)) |=> !txLoad); // R6

  AST_FCR_BANK0_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (activeBank != '0) |=> $stable(fifoCtrl)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R10
endmodule

bind banked_reg_window banked_reg_window_chk u_chk (.*);

// File: tb/banked_reg_window_bench.sv
`timescale 1ns/1ps
module banked_reg_window_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rxByte = '0;
  logic [7:0] eventId = '0;
  logic [7:0] rdData;
  logic [2:0] activeBank;
  logic [7:0] linkCtrl, txData, fifoCtrl, intEnable, modeCtrl;
  logic       txLoad;

  always #4 clk = ~clk;

  banked_reg_window u_banked_reg_window (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rxByte(rxByte), .eventId(eventId), .rdData(rdData),
    .activeBank(activeBank), .linkCtrl(linkCtrl), .txData(txData),
    .txLoad(txLoad), .fifoCtrl(fifoCtrl), .intEnable(intEnable),
    .modeCtrl(modeCtrl)
  );

  typedef struct { logic [7:0] exp; string tag; } rdItem_t;
  rdItem_t expQ[$];
  int   nChecks = 0;
  int   nFail = 0;
  logic pendRd = 1'b0;
  logic finished = 1'b0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one read result appears the cycle after each read strobe.
  always @(posedge clk) pendRd <= rdEn;
  always @(negedge clk) begin
    if (pendRd && rstN) begin
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R10 unexpected read result actual=%h expected=none", rdData);
      end else begin
        rdItem_t it;
        it = expQ.pop_front();
        check(rdData, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rdItem_t it;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    addr = a; rdEn = 1'b1; wrEn = 1'b0;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check({5'd0, activeBank}, 8'h00, "R1 bank");
    check(linkCtrl, 8'h00, "R1 linkCtrl");
    check(txData, 8'h00, "R1 txData");
    check(fifoCtrl, 8'h00, "R1 fifoCtrl");
    check({7'd0, txLoad}, 8'h00, "R1 txLoad");
    check(rdData, 8'h00, "R1 rdData");
    rd(3'd3, 8'h00, "R1 select byte");
    rd(3'd1, 8'h00, "R1 intEnable read");

    // R6 / R7 split read and write paths in bank 0
    rxByte = 8'h5A; eventId = 8'hC3;
    rd(3'd0, 8'h5A, "R6 rx read");
    rd(3'd2, 8'hC3, "R7 event read");
    wr(3'd0, 8'h77);
    check(txData, 8'h77, "R6 txData");
    check({7'd0, txLoad}, 8'h01, "R6 txLoad high");
    idle(1);
    check({7'd0, txLoad}, 8'h00, "R6 txLoad one cycle");
    rd(3'd0, 8'h5A, "R6 read still rx");
    wr(3'd2, 8'h41);
    check(fifoCtrl, 8'h41, "R7 fifoCtrl");
    rd(3'd2, 8'hC3, "R7 read still event");

    // R8 bank 0 storage
    wr(3'd1, 8'h0F); wr(3'd4, 8'h11); wr(3'd5, 8'h22); wr(3'd6, 8'h33); wr(3'd7, 8'h44);
    check(intEnable, 8'h0F, "R8 intEnable");
    check(modeCtrl, 8'h11, "R8 modeCtrl");
    rd(3'd1, 8'h0F, "R8 off1"); rd(3'd4, 8'h11, "R8 off4");
    rd(3'd5, 8'h22, "R8 off5"); rd(3'd6, 8'h33, "R8 off6"); rd(3'd7, 8'h44, "R8 off7");

    // R3 link control path
    wr(3'd3, 8'h1B);
    check(linkCtrl, 8'h1B, "R3 linkCtrl");
    check({5'd0, activeBank}, 8'h00, "R3 bank kept");
    rd(3'd3, 8'h1B, "R4 echo ctl");

    // R2 select, R5 next-cycle effect
    wr(3'd3, 8'h85);
    check({5'd0, activeBank}, 8'h05, "R2 bank5");
    check(linkCtrl, 8'h1B, "R2 link kept");
    wr(3'd1, 8'hA5);
    wr(3'd3, 8'h82);
    rd(3'd1, 8'h00, "R5 bank2 next cycle");
    wr(3'd1, 8'hB2);
    wr(3'd3, 8'h85);
    rd(3'd1, 8'hA5, "R9 bank5 private");
    rd(3'd3, 8'h85, "R4 echo in bank5");
    rxByte = 8'hE1;
    rd(3'd0, 8'h00, "R9 off0 not rx");
    rd(3'd2, 8'h00, "R9 off2 not event");
    wr(3'd0, 8'h66);
    wr(3'd2, 8'h67);
    check(txData, 8'h77, "R9 txData untouched");
    check(fifoCtrl, 8'h41, "R9 fifoCtrl untouched");
    rd(3'd0, 8'h66, "R9 off0 storage");
    rd(3'd2, 8'h67, "R9 off2 storage");

    // R2 out-of-range select
    wr(3'd3, 8'h87);
    check({5'd0, activeBank}, 8'h07, "R2 bank7");
    wr(3'd7, 8'h99);
    wr(3'd3, 8'hFF);
    check({5'd0, activeBank}, 8'h00, "R2 overrange to bank0");
    rd(3'd7, 8'h44, "R9 bank0 off7 kept");
    rd(3'd1, 8'h0F, "R9 bank0 off1 kept");
    wr(3'd3, 8'h82);
    rd(3'd1, 8'hB2, "R9 bank2 value");
    wr(3'd3, 8'h87);
    rd(3'd7, 8'h99, "R9 bank7 value");

    // R10 hold while idle
    idle(1);
    addr = 3'd0;
    idle(2);
    check(rdData, 8'h99, "R10 hold");

    finished = 1'b1;
    idle(2);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule